// File: doc/BRIEF.md
# Serial-Programmed Four-Channel Output Switch Controller

This block sits behind a serial peripheral interface slave and drives four channel-enable outputs for a low-side switch array. In each chip-select window a host shifts in one 8-bit frame and, over the same clocks, reads back a diagnostic byte. The frame carries a mode bit, three unused bits and one data bit per channel. The data bits go into an output latch only when the frame completes cleanly.

Each channel enable is the Boolean AND or OR of its latched serial data bit and a matching parallel input pin. The serial mode bit selects the operation. A program pin sets the polarity of the parallel pins, and the integrator ties it high by default. The serial pins are oversampled by the system clock through synchronizers. The serial data output comes with a separate output-enable so that the pad can tri-state it. An active-low reset clears all state and switches every channel off.

Top module: `spi_quad_switch`

## Requirements
- R1: `si_i` is sampled on each falling edge of `sclk_i` while `cs_ni` is low, most significant bit first. In the frame, bit 7 is the mode bit and bits 3..0 are the data bits for channels 3..0, active high.
- R2: The diagnostic bit 7 is on `so_o` after `cs_ni` falls and before the first clock. Each rising edge of `sclk_i` then presents the next lower bit, so bit 7-i can be read before falling edge i (i from 0).
- R3: The diagnostic byte holds `fault_i[3:0]` in bits 7..4, captured when `cs_ni` falls, and the currently latched channel data in bits 3..0.
- R4: `so_en_o` is high only while `cs_ni` is low.
- R5: When `cs_ni` rises, the frame moves into the output latch only if exactly 8 falling edges of `sclk_i` were counted. With 7 or 9 edges, the latch keeps its previous contents.
- R6: If `sclk_i` is high when `cs_ni` falls, or when `cs_ni` rises, the frame is discarded and the latch is unchanged.
- R7: Mode bit 1 selects OR and mode bit 0 selects AND between each data bit and its active parallel input. After reset the mode is AND.
- R8: With `prg_i` high a parallel input is active when high. With `prg_i` low it is active when low.
- R9: While `rst_ni` is low, all `ch_en_o` bits are 0. Reset clears the latched data and the mode, so every channel stays off after release until a valid frame arrives.
- R10: Frame bits 6..4 have no effect on the channel outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the serial pins |
| rst_ni | input | 1 | Asynchronous active-low reset, shutdown |
| sclk_i | input | 1 | Serial clock |
| cs_ni | input | 1 | Chip select, active low |
| si_i | input | 1 | Serial data in |
| so_o | output | 1 | Serial diagnostic data out |
| so_en_o | output | 1 | Output enable for the `so_o` pad driver |
| par_i | input | 4 | Parallel channel inputs |
| prg_i | input | 1 | Parallel input polarity select |
| fault_i | input | 4 | Per-channel fault flags |
| ch_en_o | output | 4 | Channel enable outputs |

## Verification
The bench builds the block with its default parameters: four channels, an 8-bit frame and a two-stage synchronizer. The serial clock runs at eight system clocks per bit. At that rate the synchronizer delay fits well inside each serial half period, so every edge of the serial pins is seen as a separate event. These values let the bench test clock counts one below and one above the frame length, and the illegal serial clock level at both chip-select edges. They also make every combination of mode, polarity and parallel pattern that the directed frames use observable at the four outputs.

// File: rtl/spi_quad_pkg.sv
package spi_quad_pkg;
  typedef enum logic {
    MODE_AND = 1'b0,
    MODE_OR  = 1'b1
  } comb_mode_e;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else if (s == 0) stg_q[s] <= d_i;
        else stg_q[s] <= stg_q[(s > 0) ? s - 1 : 0];
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx #(
  parameter int FRAME_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sclk_i,   // synchronized
  input  logic               cs_i,     // synchronized, high = deselected
  input  logic               si_i,     // synchronized
  input  logic [FRAME_W-1:0] diag_i,
  output logic               so_o,
  output logic [FRAME_W-1:0] frame_o,
  output logic               commit_o
);
  localparam int CNT_W   = $clog2(FRAME_W + 2);
  localparam int CNT_MAX = FRAME_W + 1;

  logic               sclk_d, cs_d;
  logic [FRAME_W-1:0] sreg_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               bad_q;
  logic               so_q;

  logic cs_fall, cs_rise, sclk_fall, sclk_rise;
  assign cs_fall   = cs_d & ~cs_i;
  assign cs_rise   = ~cs_d & cs_i;
  assign sclk_fall = sclk_d & ~sclk_i & ~cs_i;
  assign sclk_rise = ~sclk_d & sclk_i & ~cs_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d <= 1'b0;
      cs_d   <= 1'b1;
      sreg_q <= '0;
      cnt_q  <= '0;
      bad_q  <= 1'b0;
      so_q   <= 1'b0;
    end else begin
      sclk_d <= sclk_i;
      cs_d   <= cs_i;
      if (cs_fall) begin
        sreg_q <= diag_i;
        cnt_q  <= '0;
        bad_q  <= sclk_i;
        so_q   <= diag_i[FRAME_W-1];
      end else if (sclk_fall) begin
        sreg_q <= {sreg_q[FRAME_W-2:0], si_i};
        if (cnt_q != CNT_W'(CNT_MAX)) cnt_q <= cnt_q + 1'b1;
      end else if (sclk_rise) begin
        so_q <= sreg_q[FRAME_W-1];
      end
    end
  end

  assign so_o     = so_q;
  assign frame_o  = sreg_q;
  assign commit_o = cs_rise & (cnt_q == CNT_W'(FRAME_W)) & ~bad_q & ~sclk_i;

  p_cnt_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(CNT_MAX));

  p_diag_first_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_fall |=> so_o == $past(diag_i[FRAME_W-1]));
endmodule

// File: rtl/ch_combine.sv
module ch_combine
  import spi_quad_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic [NUM_CH-1:0] data_i,
  input  logic [NUM_CH-1:0] par_i,
  input  logic              prg_i,
  input  comb_mode_e        mode_i,
  input  logic              run_i,
  output logic [NUM_CH-1:0] ch_en_o
);
  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic par_act;
      assign par_act = prg_i ? par_i[c] : ~par_i[c];
      assign ch_en_o[c] = run_i &
        ((mode_i == MODE_OR) ? (data_i[c] | par_act) : (data_i[c] & par_act));

      always_comb begin
        if (run_i && mode_i == MODE_AND && par_i[c] != prg_i)
          p_and_off_r7: assert (!ch_en_o[c]);
        if (run_i && mode_i == MODE_OR && data_i[c])
          p_or_on_r7: assert (ch_en_o[c]);
      end
    end
  endgenerate
endmodule

// File: rtl/spi_quad_switch.sv
module spi_quad_switch
  import spi_quad_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_ni,
  input  logic              si_i,
  output logic              so_o,
  output logic              so_en_o,
  input  logic [NUM_CH-1:0] par_i,
  input  logic              prg_i,
  input  logic [NUM_CH-1:0] fault_i,
  output logic [NUM_CH-1:0] ch_en_o
);
  localparam int FRAME_W  = 2 * NUM_CH;
  localparam int MODE_BIT = FRAME_W - 1;

  logic sclk_s, cs_s, si_s;
  logic [FRAME_W-1:0] frame;
  logic commit;
  logic [NUM_CH-1:0] data_q;
  comb_mode_e mode_q;

  spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sclk_i, cs_ni, si_i}),
    .q_o   ({sclk_s, cs_s, si_s})
  );

  spi_frame_rx #(.FRAME_W(FRAME_W)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sclk_i  (sclk_s),
    .cs_i    (cs_s),
    .si_i    (si_s),
    .diag_i  ({fault_i, data_q}),
    .so_o    (so_o),
    .frame_o (frame),
    .commit_o(commit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      mode_q <= MODE_AND;
    end else if (commit) begin
      data_q <= frame[NUM_CH-1:0];
      mode_q <= frame[MODE_BIT] ? MODE_OR : MODE_AND;
    end
  end

  assign so_en_o = ~cs_ni;

  ch_combine #(.NUM_CH(NUM_CH)) u_comb (
    .data_i (data_q),
    .par_i  (par_i),
    .prg_i  (prg_i),
    .mode_i (mode_q),
    .run_i  (rst_ni),
    .ch_en_o(ch_en_o)
  );

  p_latch_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(commit) |-> $stable(data_q) && $stable(mode_q));

  always_comb begin
    if (!rst_ni) p_reset_off_r9: assert (ch_en_o == '0);
  end
endmodule

// File: tb/spi_quad_switch_tb.sv
module spi_quad_switch_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;

  logic clk = 0, rst_n = 0;
  logic sclk = 0, cs_n = 1, si = 0;
  logic so, so_en;
  logic [3:0] par = 0, fault = 0, ch_en;
  logic prg = 1;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_quad_switch u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n), .si_i(si),
    .so_o(so), .so_en_o(so_en), .par_i(par), .prg_i(prg),
    .fault_i(fault), .ch_en_o(ch_en)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [3:0] model(logic [3:0] d, bit m_or, logic [3:0] p, bit pg);
    logic [3:0] a = pg ? p : ~p;
    return m_or ? (d | a) : (d & a);
  endfunction

  task automatic frame(input logic [7:0] tx, input int nclk, input bit bad_start,
                       input bit bad_end, output logic [7:0] rx);
    rx = '0;
    if (bad_start) begin sclk = 1; wait_clk(HALF); end
    cs_n = 0; wait_clk(6);
    if (bad_start) begin sclk = 0; wait_clk(HALF); end
    for (int i = 0; i < nclk; i++) begin
      si = (i < 8) ? tx[7-i] : 1'b0;
      sclk = 1; wait_clk(HALF);
      if (i < 8) rx[7-i] = so;
      sclk = 0; wait_clk(HALF);
    end
    if (bad_end) begin sclk = 1; wait_clk(HALF); end
    cs_n = 1; wait_clk(6);
    sclk = 0; wait_clk(HALF);
  endtask

  task automatic t_reset();
    logic [7:0] rx;
    par = 4'hF; prg = 1;
    wait_clk(3);
    chk("R9 off in reset", {4'h0, ch_en}, 8'h00);
    chk("R4 so_en idle", {7'h0, so_en}, 8'h00);
    rst_n = 1; wait_clk(4);
    chk("R7 default AND, R9 data cleared", {4'h0, ch_en}, 8'h00);
    cs_n = 0; wait_clk(1);
    chk("R4 so_en selected", {7'h0, so_en}, 8'h01);
    cs_n = 1; wait_clk(6);
    frame(8'h00, 8, 0, 0, rx);
  endtask

  task automatic t_and();
    logic [7:0] rx;
    frame(8'h0A, 8, 0, 0, rx);
    par = 4'b0110; wait_clk(1);
    chk("R1 R7 AND", {4'h0, ch_en}, {4'h0, model(4'hA, 0, 4'b0110, 1)});
    par = 4'hF; wait_clk(1);
    chk("R1 AND all active", {4'h0, ch_en}, 8'h0A);
  endtask

  task automatic t_or();
    logic [7:0] rx;
    frame(8'h85, 8, 0, 0, rx);
    par = 4'b0010; wait_clk(1);
    chk("R7 OR", {4'h0, ch_en}, {4'h0, model(4'h5, 1, 4'b0010, 1)});
  endtask

  task automatic t_prg();
    prg = 0; par = 4'b1100; wait_clk(1);
    chk("R8 low active", {4'h0, ch_en}, {4'h0, model(4'h5, 1, 4'b1100, 0)});
    par = 4'hF; wait_clk(1);
    chk("R8 inactive high", {4'h0, ch_en}, 8'h05);
    prg = 1;
  endtask

  task automatic t_diag();
    logic [7:0] rx;
    fault = 4'b1001;
    frame(8'h03, 8, 0, 0, rx);
    chk("R2 R3 diag old data", rx, {4'b1001, 4'h5});
    fault = 4'b0110;
    frame(8'h03, 8, 0, 0, rx);
    chk("R3 diag new data", rx, {4'b0110, 4'h3});
    fault = 0;
  endtask

  task automatic t_count();
    logic [7:0] rx;
    par = 4'hF;
    frame(8'h0C, 7, 0, 0, rx);
    chk("R5 seven clocks kept", {4'h0, ch_en}, 8'h03);
    frame(8'h0C, 9, 0, 0, rx);
    chk("R5 nine clocks kept", {4'h0, ch_en}, 8'h03);
  endtask

  task automatic t_bad();
    logic [7:0] rx;
    frame(8'h0C, 7, 1, 0, rx);
    chk("R6 sclk high at start", {4'h0, ch_en}, 8'h03);
    frame(8'h0C, 8, 0, 1, rx);
    chk("R6 sclk high at end", {4'h0, ch_en}, 8'h03);
  endtask

  task automatic t_reserved();
    logic [7:0] rx;
    par = 4'b1010;
    frame(8'h7C, 8, 0, 0, rx);
    chk("R10 reserved ignored", {4'h0, ch_en}, {4'h0, model(4'hC, 0, 4'b1010, 1)});
    frame(8'h00, 8, 0, 0, rx);
    chk("R10 reserved readback", rx, {4'h0, 4'hC});
  endtask

  task automatic t_reset_mid();
    logic [7:0] rx;
    frame(8'h8F, 8, 0, 0, rx);
    chk("R7 OR all on", {4'h0, ch_en}, 8'h0F);
    rst_n = 0; wait_clk(2);
    chk("R9 reset forces off", {4'h0, ch_en}, 8'h00);
    rst_n = 1; wait_clk(4);
    par = 4'hF;
    wait_clk(1);
    chk("R9 R7 after release", {4'h0, ch_en}, 8'h00);
  endtask

  initial begin
    t_reset();
    t_and();
    t_or();
    t_prg();
    t_diag();
    t_count();
    t_bad();
    t_reserved();
    t_reset_mid();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule